// File: doc/BRIEF.md
# Printer Port Interrupt Controller

This block turns the two status lines coming back from a printer, the acknowledge strobe and the fault line, into latched interrupt events. It holds one 8-bit register that software reads and writes over a simple strobe-qualified register bus. The register carries a 3-bit priority level, an interrupt enable, a choice of which acknowledge edge counts, two event flags and a read-only summary bit. The block drives an interrupt request and the programmed priority level toward the system interrupt logic.

Both printer lines are asynchronous. Each passes through a two-flop synchronizer and then an edge detector, so one transition on a pin produces exactly one event pulse. Edge detection stays off until the synchronizer pipeline holds real samples, so reset cannot create a false edge. The acknowledge flag tracks the enable: it can only be set while interrupts are enabled, and writing the enable to 0 clears it. The fault flag ignores the enable. Software clears either flag by writing a 1 to its bit. When an event and a write-one-clear fall in the same cycle, the event wins.

Top module: `pp_irq_ctrl`

## Requirements
- R1: After reset, the register reads 8'h00, irq_req is 0 and irq_level is 0, and the power-up settling of the synchronizers sets no flag.
- R2: A write stores reg_wdata[4:0] into register bits 4:0. Bits 2:0 are the level, bit 3 is the enable and bit 4 is the acknowledge edge select. These bits read back unchanged, and bits 2:0 drive irq_level.
- R3: Register bit 7 is read-only and always equals bit 5 OR bit 6. A written value in bit 7 has no effect.
- R4: With bit 4 = 0 and bit 3 = 1, a rising edge on ack_in sets bit 5. A falling edge does not set it.
- R5: With bit 4 = 1 and bit 3 = 1, a falling edge on ack_in sets bit 5. A rising edge does not set it.
- R6: While bit 3 is 0, no acknowledge edge sets bit 5.
- R7: Writing 1 to bit 5 clears the acknowledge flag. Writing 0 to bit 5 leaves it unchanged.
- R8: A write with bit 3 = 0 clears bit 5. This includes the cycle in which an acknowledge edge would have set it.
- R9: A falling edge on fault_in sets bit 6 whatever the enable is. A rising edge does not set it. Only a write of 1 to bit 6 clears it. Writing the enable to 0 does not clear it.
- R10: When a flag's setting edge and a write of 1 to that flag's bit happen in the same cycle, the flag ends up set.
- R11: irq_req is 1 exactly when bit 7 and bit 3 are both 1.
- R12: A pin transition sets its flag on the third rising clock edge after it, and not before. A single transition sets the flag only once, so the flag stays clear after a later clear while the pin holds still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register contents |
| ack_in | input | 1 | Printer acknowledge line, asynchronous |
| fault_in | input | 1 | Printer fault line, asynchronous |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed interrupt priority level |

## Verification
A write takes effect at the rising edge that samples reg_wr. reg_rdata, irq_req and irq_level follow from registers through logic only, so their new values show one edge after the strobe. A pin change is due at the third rising edge after it: two synchronizer stages plus the flag register. The bench changes inputs on falling edges and samples results on falling edges. It counts exactly three rising edges before sampling a flag, and it checks at the second edge that the flag is still clear. For the same-cycle races it asserts the write strobe in the cycle before that third edge.

// File: rtl/pp_irq_pkg.sv
package pp_irq_pkg;

    localparam int REG_W     = 8;
    localparam int LEVEL_W   = 3;
    localparam int SYNC_DEPTH = 2;

    // register bit positions that software relies on
    localparam int EN_BIT    = 3;
    localparam int POL_BIT   = 4;
    localparam int ACK_BIT   = 5;
    localparam int FLT_BIT   = 6;
    localparam int PEND_BIT  = 7;

    // printer line index inside the synchronized vector
    localparam int LINE_ACK  = 0;
    localparam int LINE_FLT  = 1;
    localparam int N_LINES   = 2;

    typedef struct packed {
        logic               fall_sel;
        logic               en;
        logic [LEVEL_W-1:0] level;
    } pp_cfg_t;

    typedef struct packed {
        logic fault;
        logic ack;
    } pp_flags_t;

    function automatic pp_cfg_t pp_unpack_cfg(input logic [REG_W-1:0] w);
        pp_cfg_t c;
        c.level    = w[LEVEL_W-1:0];
        c.en       = w[EN_BIT];
        c.fall_sel = w[POL_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pp_pack(input pp_cfg_t c, input pp_flags_t f);
        logic [REG_W-1:0] r;
        r                  = '0;
        r[LEVEL_W-1:0]     = c.level;
        r[EN_BIT]          = c.en;
        r[POL_BIT]         = c.fall_sel;
        r[ACK_BIT]         = f.ack;
        r[FLT_BIT]         = f.fault;
        r[PEND_BIT]        = f.ack | f.fault;
        return r;
    endfunction

endpackage

// File: rtl/pp_sync_chain.sv
module pp_sync_chain #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pp_edge_det.sv
module pp_edge_det #(
    parameter int WIDTH = 2,
    parameter int FILL  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    localparam int CW = $clog2(FILL + 1);

    logic [WIDTH-1:0] prev;
    logic [CW-1:0]    fill_cnt;
    logic             primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= '0;
            fill_cnt <= '0;
        end else begin
            prev <= lvl;
            if (fill_cnt != CW'(FILL)) begin
                fill_cnt <= fill_cnt + 1'b1;
            end
        end
    end

    assign primed = (fill_cnt == CW'(FILL));

    for (genvar b = 0; b < WIDTH; b++) begin : g_line
        assign rise[b] = primed &  lvl[b] & ~prev[b];
        assign fall[b] = primed & ~lvl[b] &  prev[b];
    end

    // R12
    rise_once_chk: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
    // R12
    fall_once_chk: assert property (@(posedge clk) disable iff (rst)
        (fall != '0) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/pp_irq_regs.sv
module pp_irq_regs
    import pp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ack_evt,
    input  logic             flt_evt,
    output pp_cfg_t          cfg,
    output pp_flags_t        flags
);
    logic dis_wr;
    logic ack_w1c;
    logic flt_w1c;

    assign dis_wr  = wr & ~wdata[EN_BIT];
    assign ack_w1c = wr &  wdata[ACK_BIT];
    assign flt_w1c = wr &  wdata[FLT_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            flags <= '0;
        end else begin
            if (wr) begin
                cfg <= pp_unpack_cfg(wdata);
            end
            // disabling beats an edge; an edge beats write-one-clear
            if (dis_wr) begin
                flags.ack <= 1'b0;
            end else if (ack_evt && cfg.en) begin
                flags.ack <= 1'b1;
            end else if (ack_w1c) begin
                flags.ack <= 1'b0;
            end
            if (flt_evt) begin
                flags.fault <= 1'b1;
            end else if (flt_w1c) begin
                flags.fault <= 1'b0;
            end
        end
    end

    // R6
    ack_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> !flags.ack);
    // R8
    dis_clears_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata[EN_BIT]) |=> !flags.ack);
    // R10
    ack_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_evt && cfg.en && !(wr && !wdata[EN_BIT])) |=> flags.ack);
    // R9
    flt_set_chk: assert property (@(posedge clk) disable iff (rst)
        flt_evt |=> flags.fault);
    // R9
    flt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!flt_evt && !(wr && wdata[FLT_BIT])) |=> (flags.fault == $past(flags.fault)));
endmodule

// File: rtl/pp_irq_ctrl.sv
module pp_irq_ctrl
    import pp_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               ack_in,
    input  logic               fault_in,
    output logic               irq_req,
    output logic [LEVEL_W-1:0] irq_level
);
    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] fall;
    logic               ack_evt;
    logic               flt_evt;
    pp_cfg_t            cfg;
    pp_flags_t          flags;

    always_comb begin
        raw_lines           = '0;
        raw_lines[LINE_ACK] = ack_in;
        raw_lines[LINE_FLT] = fault_in;
    end

    pp_sync_chain #(.WIDTH(N_LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    pp_edge_det #(.WIDTH(N_LINES), .FILL(SYNC_DEPTH + 1)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lines),
        .rise (rise),
        .fall (fall)
    );

    assign ack_evt = cfg.fall_sel ? fall[LINE_ACK] : rise[LINE_ACK];
    assign flt_evt = fall[LINE_FLT];

    pp_irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .ack_evt (ack_evt),
        .flt_evt (flt_evt),
        .cfg     (cfg),
        .flags   (flags)
    );

    assign reg_rdata = pp_pack(cfg, flags);
    assign irq_level = cfg.level;
    assign irq_req   = cfg.en & (flags.ack | flags.fault);

    // R3
    pend_or_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[PEND_BIT] == (reg_rdata[ACK_BIT] | reg_rdata[FLT_BIT]));
    // R11
    irq_req_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req == (reg_rdata[PEND_BIT] & reg_rdata[EN_BIT]));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (reg_rdata == '0));
endmodule

// File: tb/pp_irq_ctrl_bench.sv
module pp_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ack_in = 1'b1;
    logic       fault_in = 1'b1;
    logic       irq_req;
    logic [2:0] irq_level;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_irq_ctrl u_pp_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ack_in    (ack_in),
        .fault_in  (fault_in),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status(input logic [4:0] c, input logic a, input logic f);
        return {a | f, f, a, c};
    endfunction

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_ack(input logic v);
        @(negedge clk);
        ack_in = v;
        settle();
    endtask

    task automatic drive_flt(input logic v);
        @(negedge clk);
        fault_in = v;
        settle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] cfg;
        logic       start;
        logic       exp_a;
        string      tag;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_level", irq_level, 0);
        repeat (6) @(negedge clk);
        chk("R1 no flag after settling", reg_rdata, 8'h00);

        // R2 / R3: every write value, flags idle
        for (int v = 0; v < 256; v++) begin
            wr_reg(v[7:0]);
            chk("R2 R3 readback", reg_rdata, 32'(v & 31));
            chk("R2 level", irq_level, 32'(v & 7));
            chk("R11 idle", irq_req, 0);
        end
        wr_reg(8'h00);

        // R4 R5 R6 R12: sweep polarity x enable x direction
        for (int pol = 0; pol < 2; pol++) begin
            for (int en = 0; en < 2; en++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    cfg   = 8'((pol << 4) | (en << 3) | ((pol * 4 + en * 2 + dir) & 7));
                    start = (dir == 0);
                    tag   = (en == 0) ? "R6" : ((pol == 1) ? "R5" : "R4");
                    wr_reg(cfg);
                    drive_ack(start);
                    wr_reg(cfg | 8'h60);
                    chk({tag, " baseline"}, reg_rdata, cfg);
                    @(negedge clk);
                    ack_in = ~start;
                    repeat (2) @(posedge clk);
                    @(negedge clk);
                    chk("R12 not before third edge", reg_rdata[5], 0);
                    @(posedge clk);
                    @(negedge clk);
                    exp_a = (en == 1) && ((pol == 1) ? (dir == 0) : (dir == 1));
                    chk({tag, " ack edge"}, reg_rdata, status(cfg[4:0], exp_a, 1'b0));
                    chk("R11 ack irq", irq_req, exp_a);
                    repeat (6) @(negedge clk);
                    wr_reg(cfg | 8'h20);
                    repeat (6) @(negedge clk);
                    chk("R12 single set per edge", reg_rdata[5], 0);
                end
            end
        end
        wr_reg(8'h60);

        // R7
        wr_reg(8'h08);
        drive_ack(1'b0);
        wr_reg(8'h28);
        drive_ack(1'b1);
        chk("R4 set for R7", reg_rdata, 8'hA8);
        wr_reg(8'h08);
        chk("R7 write zero keeps", reg_rdata, 8'hA8);
        wr_reg(8'h28);
        chk("R7 write one clears", reg_rdata, 8'h08);

        // R8
        drive_ack(1'b0);
        drive_ack(1'b1);
        chk("R4 set for R8", reg_rdata, 8'hA8);
        wr_reg(8'h00);
        chk("R8 disable clears", reg_rdata, 8'h00);
        wr_reg(8'h08);
        drive_ack(1'b0);
        @(negedge clk);
        ack_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = 8'h00;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 disable beats edge", reg_rdata, 8'h00);

        // R10 acknowledge
        wr_reg(8'h08);
        drive_ack(1'b0);
        @(negedge clk);
        ack_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = 8'h28;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R10 ack set wins", reg_rdata, 8'hA8);
        chk("R11 ack pending", irq_req, 1);
        wr_reg(8'h28);
        chk("R7 clear after race", reg_rdata, 8'h08);

        // R9 / R11 / R3 fault
        wr_reg(8'h00);
        drive_flt(1'b0);
        chk("R9 fault while disabled", reg_rdata, 8'hC0);
        chk("R11 no irq while disabled", irq_req, 0);
        wr_reg(8'h08);
        chk("R9 R3 fault enabled", reg_rdata, 8'hC8);
        chk("R11 fault irq", irq_req, 1);
        wr_reg(8'h00);
        chk("R9 R3 disable keeps fault", reg_rdata, 8'hC0);
        wr_reg(8'h40);
        chk("R9 write one clears", reg_rdata, 8'h00);
        drive_flt(1'b1);
        chk("R9 rising ignored", reg_rdata, 8'h00);

        // R10 fault
        @(negedge clk);
        fault_in = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = 8'h40;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R10 fault set wins", reg_rdata, 8'hC0);
        wr_reg(8'h40);
        chk("R9 clear after race", reg_rdata, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule